// File: doc/BRIEF.md
# DMA Bus Watchpoint Debug Unit

This unit sits beside a DMA controller and observes its bus ports. Each cycle, every port that carries a valid transfer has its address compared with a programmed watch condition. The condition is either one exact address or an inclusive address range. When any port hits while checking is enabled, a sticky status flag is set and a debug request toward the host CPU is raised. The request stays up until software clears the flag by writing a 1 to it.

The unit also records the channel number of the transfer that raised the flag, so the debugger can tell which DMA channel touched the watched location. If several ports hit in the same cycle, the lowest-numbered port supplies the channel. A separate active-low test reset forces the enable off without disturbing anything else.

Software reaches four word registers through a simple write port and a combinational read port. Offset 0 holds control and status, offset 1 the watch start address, offset 2 the watch end address, and offset 3 the watch mode.

Top module: `dma_watch_unit`

## Requirements
- R1: After rst_ni is deasserted, every register reads 0 and dbg_req_o is 0.
- R2: In single mode (offset 3 bit 0 = 0), a valid port hits only when its address equals the start register (offset 1). Any other address, including addresses inside start..end, never hits.
- R3: In range mode (offset 3 bit 0 = 1), a valid port hits when start <= address <= end. Both ends are included. Addresses outside that span do not hit.
- R4: A hit on any of the ports sets the status bit (offset 0 bit 16) at the next clock edge, and dbg_req_o follows the status bit. A port whose valid strobe is low never hits.
- R5: The status bit stays set until software writes offset 0 with bit 16 = 1. Writes with bit 16 = 0 leave it unchanged.
- R6: A hit in the same cycle as a write-1-to-clear leaves the status bit set.
- R7: The channel field (offset 0 bits 28:24) captures the channel of the hit that sets the status bit. Later hits do not change it while the status is set. The field keeps its value after the status is cleared.
- R8: When several ports hit in one cycle, the channel of the lowest-numbered hitting port is captured.
- R9: While the enable bit (offset 0 bit 0) is 0, no hit is detected and the status bit stays 0.
- R10: While trst_ni is low, the enable bit is forced to 0.
- R11: At offset 0, only bit 0 is writable. Bit 16 is write-1-to-clear and bits 28:24 are read-only. All other bits read 0 and ignore writes. Offsets 1 and 2 read back the written address, and offset 3 reads back only bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| trst_ni | input | 1 | Active-low test reset; clears the enable only |
| port_valid_i | input | NUM_PORTS | Per-port transfer valid strobe |
| port_addr_i | input | NUM_PORTS*ADDR_W | Per-port transfer address; port k at bits k*ADDR_W and up |
| port_chan_i | input | NUM_PORTS*CHAN_W | Per-port active channel; port k at bits k*CHAN_W and up |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| dbg_req_o | output | 1 | Debug request to the CPU |

## Verification
The bench builds the unit with three ports, a 16-bit address and a 5-bit channel. The narrow address lets it put the range edges at the neighbours of the programmed bounds and fill unused bits of the address registers with ones. Channel values up to 31 test the full width of the capture field. Multi-port patterns drive ports 0 with 2, and 1 with 2, to check priority. Other cases cover a clear that lands in the same cycle as a hit, and a test-reset pulse that arrives while checking is enabled.

// File: rtl/dwu_pkg.sv
package dwu_pkg;
  localparam int unsigned REG_W = 32;

  typedef enum logic [1:0] {
    OFS_CTRL  = 2'd0,
    OFS_START = 2'd1,
    OFS_END   = 2'd2,
    OFS_MODE  = 2'd3
  } reg_ofs_e;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_RANGE  = 1'b1
  } watch_mode_e;

  localparam int unsigned BIT_EN     = 0;
  localparam int unsigned BIT_STATUS = 16;
  localparam int unsigned POS_CHAN   = 24;
  localparam int unsigned CHAN_FIELD = 5;
endpackage

// File: rtl/dwu_port_cmp.sv
module dwu_port_cmp
  import dwu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] end_i,
  input  watch_mode_e       mode_i,
  output logic              hit_o
);
  logic at_start, above_lo, below_hi;

  always_comb begin
    at_start = (addr_i == start_i);
    above_lo = (addr_i >= start_i);
    below_hi = (addr_i <= end_i);
    hit_o    = 1'b0;
    if (valid_i) begin
      unique case (mode_i)
        MODE_SINGLE: hit_o = at_start;
        MODE_RANGE:  hit_o = above_lo && below_hi;
        default:     hit_o = 1'b0;
      endcase
    end
  end

  assert_single_exact_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SINGLE && addr_i != start_i) |-> !hit_o);

  assert_range_bounds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RANGE && (addr_i < start_i || addr_i > end_i)) |-> !hit_o);

  assert_valid_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !hit_o);
endmodule

// File: rtl/dwu_hit_select.sv
module dwu_hit_select #(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned CHAN_W    = 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic [NUM_PORTS-1:0]        hit_vec_i,
  input  logic [NUM_PORTS*CHAN_W-1:0] chan_flat_i,
  output logic                        hit_o,
  output logic [CHAN_W-1:0]           chan_o
);
  // Scan from the top so the lowest hitting port is assigned last.
  always_comb begin
    hit_o  = 1'b0;
    chan_o = '0;
    if (en_i) begin
      for (int k = NUM_PORTS - 1; k >= 0; k--) begin
        if (hit_vec_i[k]) begin
          hit_o  = 1'b1;
          chan_o = chan_flat_i[k*CHAN_W +: CHAN_W];
        end
      end
    end
  end

  assert_port0_priority_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && hit_vec_i[0]) |-> (chan_o == chan_flat_i[CHAN_W-1:0]));

  assert_disabled_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !hit_o);
endmodule

// File: rtl/dwu_regs.sv
module dwu_regs
  import dwu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CHAN_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              hit_i,
  input  logic [CHAN_W-1:0] hit_chan_i,
  output logic              dbg_en_o,
  output logic              status_o,
  output logic [ADDR_W-1:0] start_o,
  output logic [ADDR_W-1:0] end_o,
  output watch_mode_e       mode_o
);
  logic ctrl_wr, start_wr, end_wr, mode_wr, clr_req;
  logic [CHAN_W-1:0] chan_q;
  logic unused_wdata;

  assign ctrl_wr  = reg_we_i && (reg_addr_i == OFS_CTRL);
  assign start_wr = reg_we_i && (reg_addr_i == OFS_START);
  assign end_wr   = reg_we_i && (reg_addr_i == OFS_END);
  assign mode_wr  = reg_we_i && (reg_addr_i == OFS_MODE);
  assign clr_req  = ctrl_wr && reg_wdata_i[BIT_STATUS];
  assign unused_wdata = ^reg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni or negedge trst_ni) begin
    if (!rst_ni || !trst_ni) dbg_en_o <= 1'b0;
    else if (ctrl_wr)        dbg_en_o <= reg_wdata_i[BIT_EN];
  end

  // A hit outranks a clear issued in the same cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= 1'b0;
      chan_q   <= '0;
    end else begin
      if (hit_i)        status_o <= 1'b1;
      else if (clr_req) status_o <= 1'b0;
      if (hit_i && !status_o) chan_q <= hit_chan_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= '0;
      end_o   <= '0;
      mode_o  <= MODE_SINGLE;
    end else begin
      if (start_wr) start_o <= reg_wdata_i[ADDR_W-1:0];
      if (end_wr)   end_o   <= reg_wdata_i[ADDR_W-1:0];
      if (mode_wr)  mode_o  <= watch_mode_e'(reg_wdata_i[0]);
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_CTRL: begin
        reg_rdata_o[BIT_EN]              = dbg_en_o;
        reg_rdata_o[BIT_STATUS]          = status_o;
        reg_rdata_o[POS_CHAN +: CHAN_W]  = chan_q;
      end
      OFS_START: reg_rdata_o[ADDR_W-1:0] = start_o;
      OFS_END:   reg_rdata_o[ADDR_W-1:0] = end_o;
      OFS_MODE:  reg_rdata_o[0]          = mode_o;
      default:   reg_rdata_o = '0;
    endcase
  end

  assert_hit_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> status_o);

  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && !clr_req) |=> status_o);

  assert_hit_beats_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && clr_req) |=> status_o);

  assert_chan_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o |=> $stable(chan_q));

  assert_trst_forces_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trst_ni |-> !dbg_en_o);

  assert_status_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o && !dbg_en_o) |=> !status_o);
endmodule

// File: rtl/dma_watch_unit.sv
module dma_watch_unit
  import dwu_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CHAN_W    = 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        trst_ni,
  input  logic [NUM_PORTS-1:0]        port_valid_i,
  input  logic [NUM_PORTS*ADDR_W-1:0] port_addr_i,
  input  logic [NUM_PORTS*CHAN_W-1:0] port_chan_i,
  input  logic                        reg_we_i,
  input  logic [1:0]                  reg_addr_i,
  input  logic [REG_W-1:0]            reg_wdata_i,
  output logic [REG_W-1:0]            reg_rdata_o,
  output logic                        dbg_req_o
);
  localparam int unsigned CHAN_MAX = CHAN_FIELD;

  logic                 dbg_en, status, hit_any;
  logic [NUM_PORTS-1:0] hit_vec;
  logic [CHAN_W-1:0]    hit_chan;
  logic [ADDR_W-1:0]    watch_start, watch_end;
  watch_mode_e          watch_mode;

  initial begin
    if (CHAN_W > CHAN_MAX || ADDR_W > REG_W || NUM_PORTS < 1)
      $error("dma_watch_unit: unsupported parameters");
  end

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    dwu_port_cmp #(.ADDR_W(ADDR_W)) i_cmp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (port_valid_i[k]),
      .addr_i  (port_addr_i[k*ADDR_W +: ADDR_W]),
      .start_i (watch_start),
      .end_i   (watch_end),
      .mode_i  (watch_mode),
      .hit_o   (hit_vec[k])
    );
  end

  dwu_hit_select #(.NUM_PORTS(NUM_PORTS), .CHAN_W(CHAN_W)) i_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (dbg_en),
    .hit_vec_i   (hit_vec),
    .chan_flat_i (port_chan_i),
    .hit_o       (hit_any),
    .chan_o      (hit_chan)
  );

  dwu_regs #(.ADDR_W(ADDR_W), .CHAN_W(CHAN_W)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trst_ni     (trst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .hit_i       (hit_any),
    .hit_chan_i  (hit_chan),
    .dbg_en_o    (dbg_en),
    .status_o    (status),
    .start_o     (watch_start),
    .end_o       (watch_end),
    .mode_o      (watch_mode)
  );

  assign dbg_req_o = status;

  assert_any_port_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_en && |hit_vec) |=> dbg_req_o);

  assert_enable_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbg_req_o && !dbg_en) |=> !dbg_req_o);
endmodule

// File: tb/test_dma_watch_unit.sv
module test_dma_watch_unit;
  localparam int unsigned NP = 3;
  localparam int unsigned AW = 16;
  localparam int unsigned CW = 5;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              trst_ni = 1'b1;
  logic [NP-1:0]     port_valid_i = '0;
  logic [NP*AW-1:0]  port_addr_i = '0;
  logic [NP*CW-1:0]  port_chan_i = '0;
  logic              reg_we_i = 1'b0;
  logic [1:0]        reg_addr_i = '0;
  logic [31:0]       reg_wdata_i = '0;
  logic [31:0]       reg_rdata_o;
  logic              dbg_req_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  dma_watch_unit #(.NUM_PORTS(NP), .ADDR_W(AW), .CHAN_W(CW)) i_dma_watch_unit (.*);

  function automatic logic [31:0] ctrl_word(logic en, logic st, logic [4:0] ch);
    return {3'b0, ch, 7'b0, st, 15'b0, en};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  // One cycle of port traffic, optionally with a concurrent register write.
  task automatic drive(logic [NP-1:0] v, logic [AW-1:0] a0, a1, a2,
                       logic [CW-1:0] c0, c1, c2, logic do_wr = 1'b0,
                       logic [31:0] wd = '0);
    @(negedge clk_i);
    port_valid_i = v;
    port_addr_i  = {a2, a1, a0};
    port_chan_i  = {c2, c1, c0};
    if (do_wr) begin reg_we_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = wd; end
    @(posedge clk_i); #1;
    port_valid_i = '0; reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check("R1 reg after reset", d, 32'h0);
    end
    check("R1 dbg_req after reset", {31'b0, dbg_req_o}, 32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); check("R11 ctrl writable bits", d, ctrl_word(1, 0, 0));
    wr(2'd1, 32'hFFFF_1234);
    rd(2'd1, d); check("R11 start readback", d, 32'h0000_1234);
    wr(2'd2, 32'hABCD_5678);
    rd(2'd2, d); check("R11 end readback", d, 32'h0000_5678);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, d); check("R11 mode readback", d, 32'h1);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_single();
    logic [31:0] d;
    wr(2'd3, 32'h0); wr(2'd1, 32'h0100); wr(2'd2, 32'h0200); wr(2'd0, 32'h1);
    drive(3'b010, 0, 16'h0101, 0, 0, 5, 0);
    check("R2 near address no hit", {31'b0, dbg_req_o}, 0);
    drive(3'b010, 0, 16'h0180, 0, 0, 5, 0);
    check("R2 in-span address no hit in single mode", {31'b0, dbg_req_o}, 0);
    drive(3'b010, 0, 16'h0100, 0, 0, 7, 0);
    check("R4 dbg_req after exact hit", {31'b0, dbg_req_o}, 1);
    rd(2'd0, d); check("R2 R7 ctrl after hit", d, ctrl_word(1, 1, 7));
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    wr(2'd0, 32'h1);
    rd(2'd0, d); check("R5 write 0 to status keeps it", d, ctrl_word(1, 1, 7));
    drive(3'b100, 0, 0, 16'h0100, 0, 0, 9);
    rd(2'd0, d); check("R7 later hit keeps channel", d, ctrl_word(1, 1, 7));
    wr(2'd0, 32'h0001_0001);
    check("R5 dbg_req drops after clear", {31'b0, dbg_req_o}, 0);
    rd(2'd0, d); check("R7 channel kept after clear", d, ctrl_word(1, 0, 7));
  endtask

  task automatic t_range();
    logic [31:0] d;
    wr(2'd3, 32'h1); wr(2'd1, 32'h0200); wr(2'd2, 32'h02FF);
    drive(3'b001, 16'h01FF, 0, 0, 1, 0, 0);
    check("R3 below start no hit", {31'b0, dbg_req_o}, 0);
    drive(3'b001, 16'h0300, 0, 0, 1, 0, 0);
    check("R3 above end no hit", {31'b0, dbg_req_o}, 0);
    drive(3'b001, 16'h02FF, 0, 0, 3, 0, 0);
    rd(2'd0, d); check("R3 end address hits", d, ctrl_word(1, 1, 3));
    wr(2'd0, 32'h0001_0001);
    drive(3'b100, 0, 0, 16'h0200, 0, 0, 31);
    rd(2'd0, d); check("R3 R4 start address on port 2", d, ctrl_word(1, 1, 31));
    wr(2'd0, 32'h0001_0001);
    drive(3'b000, 16'h0250, 16'h0250, 16'h0250, 4, 4, 4);
    check("R4 invalid ports never hit", {31'b0, dbg_req_o}, 0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    drive(3'b101, 16'h0210, 0, 16'h0220, 11, 0, 22);
    rd(2'd0, d); check("R8 port 0 over port 2", d, ctrl_word(1, 1, 11));
    wr(2'd0, 32'h0001_0001);
    drive(3'b110, 0, 16'h0230, 16'h0240, 0, 13, 22);
    rd(2'd0, d); check("R8 port 1 over port 2", d, ctrl_word(1, 1, 13));
  endtask

  task automatic t_clear_race();
    logic [31:0] d;
    drive(3'b001, 16'h0210, 0, 0, 2, 0, 0, 1'b1, 32'h0001_0001);
    rd(2'd0, d); check("R6 hit wins over clear", d, ctrl_word(1, 1, 13));
    wr(2'd0, 32'h0001_0001);
    rd(2'd0, d); check("R5 plain clear", d, ctrl_word(1, 0, 13));
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    wr(2'd0, 32'h0);
    drive(3'b111, 16'h0200, 16'h0250, 16'h02FF, 1, 2, 3);
    check("R9 no request while disabled", {31'b0, dbg_req_o}, 0);
    rd(2'd0, d); check("R9 status clear while disabled", d, ctrl_word(0, 0, 13));
  endtask

  task automatic t_trst();
    logic [31:0] d;
    wr(2'd0, 32'h1);
    @(negedge clk_i); trst_ni = 1'b0;
    #1 reg_addr_i = 2'd0;
    #1 check("R10 enable off during test reset", reg_rdata_o, ctrl_word(0, 0, 13));
    @(negedge clk_i); trst_ni = 1'b1;
    drive(3'b001, 16'h0200, 0, 0, 6, 0, 0);
    check("R10 no hit after test reset", {31'b0, dbg_req_o}, 0);
    rd(2'd1, d); check("R10 test reset keeps other regs", d, 32'h0200);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk_i);
        #1 rst_ni = 1'b1;
        t_reset();
        t_layout();
        t_single();
        t_sticky();
        t_range();
        t_priority();
        t_clear_race();
        t_disabled();
        t_trst();
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule